// File: doc/BRIEF.md
# Cascaded Serial Clock Divider Chain

This block turns one peripheral clock into a family of single-cycle enable strobes for a serial protocol engine. Every output is a one-cycle pulse in the clock domain of `clk`. No derived clock is ever produced. The chain has five stages:

- **Protocol stage.** The reference rate is one pulse per enabled cycle. This stage either passes that rate through or halves it.
- **Main divider.** It divides the protocol strobe by a 10-bit programmable value.
- **Sample-source multiplexer.** It picks one of four strobes as the sample strobe: the divided strobe, the protocol strobe, an external serial-bit strobe, or the reference.
- **Pre-divider.** A 2-bit divider takes the sample strobe.
- **Denominator divider.** A 5-bit divider follows the pre-divider and produces the sample-counter strobe.

All configuration inputs are static register values, held by the surrounding logic. The block has no data stream, so no valid/ready handshake applies. Every pin is a plain control or strobe signal.

Each divider counts the pulses it receives and fires on every (N+1)-th one. It reloads its count to zero in two cases: when the block is disabled, and on any cycle in which its divisor input differs from the value seen in the previous cycle.

Top module: `sdiv_chain`

## Requirements
- R1: While `enable` is 0, every strobe output is 0, whatever `bit_stb` and the configuration are. Every divider count and the halving toggle return to zero, so that the next enabled cycle starts a fresh count.
- R2: `prot_stb` pulses on every enabled cycle when `half_sel` is 0. When `half_sel` is 1, it pulses on every second enabled cycle, starting with the second one. Over W enabled cycles that gives W or floor(W/2) pulses.
- R3: From a fresh start, `div_stb` gives floor(P/(`main_div`+1)) pulses, where P is the number of `prot_stb` pulses. A pulse coincides with every (`main_div`+1)-th protocol pulse.
- R4: `samp_stb` follows `samp_sel`, with these codes: 2'b00 gives the divided strobe, 2'b01 the protocol strobe, 2'b10 `bit_stb` (gated by `enable`), and 2'b11 the reference, which is every enabled cycle.
- R5: From a fresh start, `pre_stb` gives floor(S/(`pre_div`+1)) pulses, where S is the number of sample pulses.
- R6: From a fresh start, `cnt_stb` gives floor(Q/(`den_div`+1)) pulses, where Q is the number of pre-divider pulses.
- R7: A divisor value of 0 makes a divider pass its input strobe through unchanged in the same cycle. With all divisors 0, `half_sel`=0 and `samp_sel`=2'b00, every output pulses on every enabled cycle.
- R8: In a cycle where a divisor input changes, that divider does not fire. It then counts from zero: after `main_div` changes to N, the next pulse comes on the (N+1)-th protocol pulse after the change cycle.
- R9: The strobes nest. `div_stb` implies `prot_stb`, `pre_stb` implies `samp_stb`, and `cnt_stb` implies `pre_stb`, all in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Chain enable; 0 clears all counters |
| half_sel | input | 1 | 1 halves the protocol strobe rate |
| main_div | input | 10 | Main divisor minus one |
| samp_sel | input | 2 | Sample strobe source code |
| pre_div | input | 2 | Pre-divider divisor minus one |
| den_div | input | 5 | Denominator divisor minus one |
| bit_stb | input | 1 | External synchronised serial-bit pulse |
| prot_stb | output | 1 | Protocol-rate strobe |
| div_stb | output | 1 | Main divided strobe |
| samp_stb | output | 1 | Selected sample strobe |
| pre_stb | output | 1 | Pre-divided sample strobe |
| cnt_stb | output | 1 | Sample-counter strobe |

## Verification
The bench counts each output's pulses over fixed enabled windows and compares every count with the floor-division rate formulas. Because each stage feeds the next, a wrong divisor, an off-by-one count or a wrong stage order shows up as a mismatch further down the chain.

Random configurations cover both halving settings, all four source codes and a spread of divisors. A randomly spaced serial-bit pulse shows whether code 2'b10 really follows the external input rather than an internal strobe.

Directed cases cover three situations:
- All divisors at zero, which exposes any latency or swallowed pulse in the pass-through path.
- A divisor change in the middle of a count, which separates a true reload from a counter that keeps its stale value.
- A disabled window with the serial-bit input held high, which shows that nothing leaks through while the block is off.

// File: rtl/sdiv_pkg.sv
`timescale 1ns/1ps
package sdiv_pkg;
  typedef enum logic [1:0] {
    SRC_DIV  = 2'b00,
    SRC_PROT = 2'b01,
    SRC_BIT  = 2'b10,
    SRC_REF  = 2'b11
  } samp_src_e;
endpackage

// File: rtl/sdiv_proto_stage.sv
`timescale 1ns/1ps
module sdiv_proto_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic half_i,
  output logic out_stb_o
);
  logic tgl_q;
  logic half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgl_q  <= 1'b0;
      half_q <= 1'b0;
    end else begin
      half_q <= half_i;
      if (!en_i || !half_i || (half_i != half_q)) tgl_q <= 1'b0;
      else                                        tgl_q <= ~tgl_q;
    end
  end

  assign out_stb_o = en_i && (!half_i || tgl_q);

  // R2
  half_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (half_i && out_stb_o) |=> (!half_i || !out_stb_o));

  // R1
  proto_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> !out_stb_o);
endmodule

// File: rtl/sdiv_stage.sv
`timescale 1ns/1ps
module sdiv_stage #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         in_stb_i,
  input  logic [W-1:0] div_i,
  output logic         out_stb_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] div_q;
  logic         changed;

  assign changed = (div_i != div_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      div_q <= '0;
    end else begin
      div_q <= div_i;
      if (!en_i || changed)   cnt_q <= '0;
      else if (in_stb_i)      cnt_q <= (cnt_q == div_i) ? '0 : cnt_q + ONE;
    end
  end

  assign out_stb_o = en_i && in_stb_i && !changed && (cnt_q == div_i);

  // R9
  out_needs_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_stb_o |-> in_stb_i);

  // R1
  stage_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (cnt_q == '0));

  // R8
  reload_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_i != $past(div_i)) |=> (cnt_q == '0));

  // R3
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !changed) |-> (cnt_q <= div_i));
endmodule

// File: rtl/sdiv_src_mux.sv
`timescale 1ns/1ps
module sdiv_src_mux
  import sdiv_pkg::*;
(
  input  logic       en_i,
  input  logic [1:0] sel_i,
  input  logic       div_stb_i,
  input  logic       prot_stb_i,
  input  logic       bit_stb_i,
  output logic       samp_stb_o
);
  samp_src_e src;
  assign src = samp_src_e'(sel_i);

  always_comb begin
    samp_stb_o = 1'b0;
    unique case (src)
      SRC_DIV:  samp_stb_o = div_stb_i;
      SRC_PROT: samp_stb_o = prot_stb_i;
      SRC_BIT:  samp_stb_o = bit_stb_i && en_i;
      SRC_REF:  samp_stb_o = en_i;
      default:  samp_stb_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/sdiv_chain.sv
`timescale 1ns/1ps
module sdiv_chain #(
  parameter int MAIN_W = 10,
  parameter int PRE_W  = 2,
  parameter int DEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              half_sel,
  input  logic [MAIN_W-1:0] main_div,
  input  logic [1:0]        samp_sel,
  input  logic [PRE_W-1:0]  pre_div,
  input  logic [DEN_W-1:0]  den_div,
  input  logic              bit_stb,
  output logic              prot_stb,
  output logic              div_stb,
  output logic              samp_stb,
  output logic              pre_stb,
  output logic              cnt_stb
);
  sdiv_proto_stage u_proto (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (enable),
    .half_i    (half_sel),
    .out_stb_o (prot_stb)
  );

  sdiv_stage #(.W(MAIN_W)) u_main (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (enable),
    .in_stb_i  (prot_stb),
    .div_i     (main_div),
    .out_stb_o (div_stb)
  );

  sdiv_src_mux u_mux (
    .en_i       (enable),
    .sel_i      (samp_sel),
    .div_stb_i  (div_stb),
    .prot_stb_i (prot_stb),
    .bit_stb_i  (bit_stb),
    .samp_stb_o (samp_stb)
  );

  sdiv_stage #(.W(PRE_W)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (enable),
    .in_stb_i  (samp_stb),
    .div_i     (pre_div),
    .out_stb_o (pre_stb)
  );

  sdiv_stage #(.W(DEN_W)) u_den (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (enable),
    .in_stb_i  (pre_stb),
    .div_i     (den_div),
    .out_stb_o (cnt_stb)
  );

  // R9
  div_in_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_stb |-> prot_stb);

  // R9
  cnt_in_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_stb |-> (pre_stb && samp_stb));

  // R1
  chain_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !(prot_stb || div_stb || samp_stb || pre_stb || cnt_stb));
endmodule

// File: tb/sdiv_chain_tb.sv
`timescale 1ns/1ps
module sdiv_chain_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       half_sel = 1'b0;
  logic [9:0] main_div = '0;
  logic [1:0] samp_sel = '0;
  logic [1:0] pre_div = '0;
  logic [4:0] den_div = '0;
  logic       bit_stb = 1'b0;
  logic       prot_stb, div_stb, samp_stb, pre_stb, cnt_stb;

  int vectors = 0;
  int miscompares = 0;
  int n_prot, n_div, n_samp, n_pre, n_cnt, n_bit, nest_bad;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdiv_chain u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .half_sel(half_sel),
    .main_div(main_div), .samp_sel(samp_sel), .pre_div(pre_div),
    .den_div(den_div), .bit_stb(bit_stb), .prot_stb(prot_stb),
    .div_stb(div_stb), .samp_stb(samp_stb), .pre_stb(pre_stb),
    .cnt_stb(cnt_stb)
  );

  task automatic chk(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  function automatic int exp_prot(int w, logic h);
    return h ? w / 2 : w;
  endfunction

  function automatic int exp_samp(int w, int p, int d, int b, logic [1:0] s);
    case (s)
      2'b00:   return d;
      2'b01:   return p;
      2'b10:   return b;
      default: return w;
    endcase
  endfunction

  task automatic clear_counts();
    n_prot = 0; n_div = 0; n_samp = 0; n_pre = 0; n_cnt = 0;
    n_bit = 0; nest_bad = 0;
  endtask

  task automatic sample_cycle();
    #1;
    if (prot_stb) n_prot++;
    if (div_stb)  n_div++;
    if (samp_stb) n_samp++;
    if (pre_stb)  n_pre++;
    if (cnt_stb)  n_cnt++;
    if ((div_stb && !prot_stb) || (pre_stb && !samp_stb) || (cnt_stb && !pre_stb))
      nest_bad++;
  endtask

  task automatic set_cfg(logic h, int m, int s, int p, int q);
    @(negedge clk);
    enable = 1'b0; bit_stb = 1'b0;
    half_sel = h; main_div = 10'(m); samp_sel = 2'(s);
    pre_div = 2'(p); den_div = 5'(q);
    repeat (2) @(negedge clk);
  endtask

  task automatic run_window(int w, int bitmod);
    int ep, ed, es, epr, ec;
    clear_counts();
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      enable = 1'b1;
      bit_stb = (bitmod > 0) && (($urandom % bitmod) == 0);
      if (bit_stb) n_bit++;
      sample_cycle();
    end
    @(negedge clk);
    enable = 1'b0; bit_stb = 1'b0;
    ep  = exp_prot(w, half_sel);
    ed  = ep / (int'(main_div) + 1);
    es  = exp_samp(w, ep, ed, n_bit, samp_sel);
    epr = es / (int'(pre_div) + 1);
    ec  = epr / (int'(den_div) + 1);
    chk("R2", "prot count", n_prot, ep);
    chk("R3", "div count",  n_div,  ed);
    chk("R4", "samp count", n_samp, es);
    chk("R5", "pre count",  n_pre,  epr);
    chk("R6", "cnt count",  n_cnt,  ec);
    chk("R9", "nesting violations", nest_bad, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1", "strobes in reset", {prot_stb, div_stb, samp_stb, pre_stb, cnt_stb}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1", "strobes after reset, disabled",
        {prot_stb, div_stb, samp_stb, pre_stb, cnt_stb}, 0);

    // R7 all divisors zero: full pass-through
    set_cfg(1'b0, 0, 0, 0, 0);
    run_window(64, 0);
    chk("R7", "pass-through cnt count", n_cnt, 64);

    // R4 each source code, fixed divisors
    set_cfg(1'b1, 2, 0, 1, 2); run_window(300, 0);
    set_cfg(1'b1, 2, 1, 1, 2); run_window(300, 0);
    set_cfg(1'b0, 4, 2, 0, 1); run_window(300, 3);
    set_cfg(1'b0, 4, 3, 3, 4); run_window(300, 0);

    // R1 disabled: nothing leaks even with bit strobe and ref source
    set_cfg(1'b0, 0, 3, 0, 0);
    clear_counts();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      enable = 1'b0; bit_stb = 1'b1;
      sample_cycle();
    end
    bit_stb = 1'b0;
    chk("R1", "strobes while disabled", n_prot + n_div + n_samp + n_pre + n_cnt, 0);

    // R8 divisor change mid-count reloads to zero
    set_cfg(1'b0, 3, 1, 0, 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      enable = 1'b1;
    end
    @(negedge clk);
    main_div = 10'd1;
    #1;
    chk("R8", "div strobe in change cycle", int'(div_stb), 0);
    clear_counts();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      sample_cycle();
    end
    chk("R8", "div count after reload", n_div, 10);
    @(negedge clk);
    enable = 1'b0;

    // random configurations
    for (int k = 0; k < 10; k++) begin
      set_cfg(1'($urandom % 2), int'($urandom % 6), int'($urandom % 4),
              int'($urandom % 4), int'($urandom % 8));
      run_window(400, 2 + int'($urandom % 4));
    end

    finish_run();
  end
endmodule